// File: doc/BRIEF.md
# Adaptive Playout Buffer with Output-Rate Trim

This block sits on the receive side of a packet audio link. Samples come in bursts as packets are unpacked, and one sample must leave on every tick of the local output sample strobe. The block keeps incoming samples in a FIFO so that late or bunched packets do not cause gaps. The FIFO's fill level is used to steer the local sample clock.

After a connection opens, the block holds playout until the FIFO has filled to its midpoint. From then on, each strobe tick removes one sample. On each tick the block compares the fill level with a low and a high threshold. If the level lies outside that band, it sends a fixed one-step trim command, with a sign, to an external numerically controlled clock. A filling FIFO means the output is too slow, so the command asks for a faster clock. A draining FIFO asks for a slower clock. After each command, a hold-off timer counted in sample ticks blocks further commands, so corrections stay slow and low-frequency jitter stays small. The block also keeps a saturating running sum of the commands it has issued. Underrun and overrun are reported by sticky flags that clear only on reset.

Top module: `playout_buf`

## Requirements
- R1: After reset, fill_level, playing, rd_valid, underrun, overrun, trim_pulse and trim_total are all zero.
- R2: While playing is 0, a strobe tick removes nothing, raises no rd_valid and raises no trim_pulse.
- R3: playing goes to 1 one cycle after the registered fill_level first reaches DEPTH/2. It then stays at 1 until reset.
- R4: While playing is 1, a tick with fill_level > 0 pops one sample. In the following cycle, rd_valid is 1, rd_data holds the oldest stored sample (first in, first out) and fill_level has dropped by one, less any accepted write.
- R5: While playing is 1, a tick with fill_level = 0 makes rd_valid 1 with rd_data = 0 in the next cycle and sets underrun. Underrun stays set until reset.
- R6: A write arriving while fill_level = DEPTH is dropped, even if the same cycle pops a sample. The write leaves fill_level unchanged, sets overrun (sticky until reset) and never appears on rd_data.
- R7: A tick that is allowed to trim, with fill_level > hi_lim, gives trim_pulse = 1 and trim_up = 1 in the next cycle, and trim_total rises by one.
- R8: A tick that is allowed to trim, with fill_level < lo_lim, gives trim_pulse = 1 and trim_up = 0 in the next cycle, and trim_total falls by one.
- R9: A tick with lo_lim <= fill_level <= hi_lim issues no trim command.
- R10: Once a command has been issued on tick t, ticks t+1 to t+HOLD_TICKS-1 issue none. Tick t+HOLD_TICKS is again allowed to trim. The first tick after playing rises is allowed to trim.
- R11: trim_total is a signed TRIM_W-bit value. It holds at its largest value on a further up command and at its smallest on a further down command. trim_pulse is still issued in those cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts a new connection |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | DATA_W | Sample to store |
| smp_tick | input | 1 | Output sample strobe, one cycle per sample |
| lo_lim | input | ADDR_W+1 | Low fill threshold |
| hi_lim | input | ADDR_W+1 | High fill threshold |
| rd_data | output | DATA_W | Sample played out (0 on underrun) |
| rd_valid | output | 1 | rd_data is new this cycle |
| playing | output | 1 | Playout has started |
| fill_level | output | ADDR_W+1 | Samples held in the FIFO |
| underrun | output | 1 | Sticky: a tick found the FIFO empty |
| overrun | output | 1 | Sticky: a write found the FIFO full |
| trim_pulse | output | 1 | One-cycle trim command |
| trim_up | output | 1 | Direction of trim_pulse: 1 = faster, 0 = slower |
| trim_total | output | TRIM_W | Saturating signed sum of commands |

## Verification
Every result lands exactly one cycle after the edge that took its stimulus: rd_data/rd_valid, trim_pulse/trim_up/trim_total, fill_level, and the sticky flags. The one exception is playing, which needs two cycles after the write that brings the level to the midpoint. The driver keeps a reference model and pushes each expected read and trim into a queue, stamped with the cycle in which it is due. The monitor samples on the falling edge and fails any output that arrives early, arrives late, has no matching entry, or leaves an entry unconsumed. Explicit checks on levels, flags and pulse counts are also taken at the falling edge after the step that must produce them.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [1:0] {
    TRIM_HOLD = 2'd0,
    TRIM_FAST = 2'd1,
    TRIM_SLOW = 2'd2
  } trim_req_e;
endpackage

// File: rtl/pb_level.sv
module pb_level #(
  parameter int ADDR_W = 6,
  localparam int LVL_W = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             smp_tick,
  output logic             push,
  output logic             pop,
  output logic             starve,
  output logic [LVL_W-1:0] level,
  output logic             playing,
  output logic             underrun,
  output logic             overrun
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);

  logic is_full, is_empty;
  assign is_full  = (level == FULL);
  assign is_empty = (level == '0);
  assign push     = wr_en && !is_full;
  assign pop      = smp_tick && playing && !is_empty;
  assign starve   = smp_tick && playing && is_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      level    <= '0;
      playing  <= 1'b0;
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      level <= level + LVL_W'(push) - LVL_W'(pop);
      if (level >= HALF) playing <= 1'b1;
      if (starve) underrun <= 1'b1;
      if (wr_en && is_full) overrun <= 1'b1;
    end
  end

  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_full) |=> (overrun && level <= FULL));

  // R5
  underrun_chk: assert property (@(posedge clk) disable iff (rst)
    starve |=> underrun);

  // R3
  play_hold_chk: assert property (@(posedge clk) disable iff (rst)
    playing |=> playing);
endmodule

// File: rtl/pb_store.sv
module pb_store #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic              starve,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= pop || starve;
      if (push) wptr <= wptr + 1'b1;
      if (pop) begin
        rd_data <= mem[rptr];
        rptr    <= rptr + 1'b1;
      end else if (starve) begin
        rd_data <= '0;
      end
    end
  end

  // R5
  starve_zero_chk: assert property (@(posedge clk) disable iff (rst)
    starve |=> (rd_valid && rd_data == '0));

  // R4
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    !(pop && starve));
endmodule

// File: rtl/pb_trim.sv
module pb_trim
  import pb_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int HOLD_TICKS = 96000,
  parameter int TRIM_W     = 8,
  localparam int LVL_W     = ADDR_W + 1,
  localparam int CNT_W     = $clog2(HOLD_TICKS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_tick,
  input  logic                     playing,
  input  logic [LVL_W-1:0]         level,
  input  logic [LVL_W-1:0]         lo_lim,
  input  logic [LVL_W-1:0]         hi_lim,
  output logic                     trim_pulse,
  output logic                     trim_up,
  output logic signed [TRIM_W-1:0] trim_total
);
  localparam logic signed [TRIM_W-1:0] TMAX = {1'b0, {(TRIM_W-1){1'b1}}};
  localparam logic signed [TRIM_W-1:0] TMIN = {1'b1, {(TRIM_W-1){1'b0}}};

  logic [CNT_W-1:0] hold_cnt;
  logic             armed, live;
  trim_req_e        req;

  assign armed = (hold_cnt == '0);
  assign live  = smp_tick && playing;

  always_comb begin
    req = TRIM_HOLD;
    if (level > hi_lim)      req = TRIM_FAST;
    else if (level < lo_lim) req = TRIM_SLOW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt   <= '0;
      trim_pulse <= 1'b0;
      trim_up    <= 1'b0;
      trim_total <= '0;
    end else begin
      trim_pulse <= 1'b0;
      if (live) begin
        if (armed && req != TRIM_HOLD) begin
          trim_pulse <= 1'b1;
          trim_up    <= (req == TRIM_FAST);
          hold_cnt   <= CNT_W'(HOLD_TICKS - 1);
          if (req == TRIM_FAST && trim_total != TMAX)
            trim_total <= trim_total + 1'b1;
          else if (req == TRIM_SLOW && trim_total != TMIN)
            trim_total <= trim_total - 1'b1;
        end else if (!armed) begin
          hold_cnt <= hold_cnt - 1'b1;
        end
      end
    end
  end

  // Checker state: sample ticks seen since the last trim command.
  logic [CNT_W:0] gap;
  logic           seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (trim_pulse) begin
      gap  <= (CNT_W+1)'(smp_tick);
      seen <= 1'b1;
    end else if (smp_tick && gap != (CNT_W+1)'(HOLD_TICKS)) begin
      gap <= gap + 1'b1;
    end
  end

  // R10
  holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    (trim_pulse && seen) |-> (gap >= (CNT_W+1)'(HOLD_TICKS)));

  // R11
  sat_up_chk: assert property (@(posedge clk) disable iff (rst)
    (trim_pulse && trim_up) |-> (trim_total >= $past(trim_total)));

  // R11
  sat_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (trim_pulse && !trim_up) |-> (trim_total <= $past(trim_total)));

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !playing |=> !trim_pulse);
endmodule

// File: rtl/playout_buf.sv
module playout_buf #(
  parameter int DATA_W     = 24,
  parameter int ADDR_W     = 6,
  parameter int HOLD_TICKS = 96000,
  parameter int TRIM_W     = 8,
  localparam int LVL_W     = ADDR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     smp_tick,
  input  logic [LVL_W-1:0]         lo_lim,
  input  logic [LVL_W-1:0]         hi_lim,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic                     playing,
  output logic [LVL_W-1:0]         fill_level,
  output logic                     underrun,
  output logic                     overrun,
  output logic                     trim_pulse,
  output logic                     trim_up,
  output logic signed [TRIM_W-1:0] trim_total
);
  logic push, pop, starve;

  pb_level #(.ADDR_W(ADDR_W)) u_level (
    .clk(clk), .rst(rst), .wr_en(wr_en), .smp_tick(smp_tick),
    .push(push), .pop(pop), .starve(starve), .level(fill_level),
    .playing(playing), .underrun(underrun), .overrun(overrun)
  );

  pb_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .starve(starve),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  pb_trim #(.ADDR_W(ADDR_W), .HOLD_TICKS(HOLD_TICKS), .TRIM_W(TRIM_W)) u_trim (
    .clk(clk), .rst(rst), .smp_tick(smp_tick), .playing(playing),
    .level(fill_level), .lo_lim(lo_lim), .hi_lim(hi_lim),
    .trim_pulse(trim_pulse), .trim_up(trim_up), .trim_total(trim_total)
  );

  // R2
  no_read_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_tick && !playing) |=> !rd_valid);
endmodule

// File: tb/sim_playout_buf.sv
`timescale 1ns/1ps
module sim_playout_buf;
  localparam int DW = 16, AW = 4, HT = 6, TW = 4;
  localparam int LW = AW + 1, D = 1 << AW;
  localparam int LO = 5, HI = 11;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, smp_tick = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] lo_lim = LW'(LO), hi_lim = LW'(HI);
  logic [DW-1:0] rd_data;
  logic rd_valid, playing, underrun, overrun, trim_pulse, trim_up;
  logic [LW-1:0] fill_level;
  logic signed [TW-1:0] trim_total;

  always #2.5 clk = ~clk;

  playout_buf #(.DATA_W(DW), .ADDR_W(AW), .HOLD_TICKS(HT), .TRIM_W(TW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .smp_tick(smp_tick),
    .lo_lim(lo_lim), .hi_lim(hi_lim), .rd_data(rd_data), .rd_valid(rd_valid),
    .playing(playing), .fill_level(fill_level), .underrun(underrun),
    .overrun(overrun), .trim_pulse(trim_pulse), .trim_up(trim_up),
    .trim_total(trim_total)
  );

  int checks = 0, fails = 0, cyc = 0, pulses = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model state
  int m_lvl = 0, m_cnt = 0, m_tot = 0;
  bit m_play = 1'b0;
  logic [DW-1:0] m_fifo[$];
  int rq_due[$]; logic [DW-1:0] rq_val[$];
  int tq_due[$]; bit tq_up[$]; int tq_tot[$];

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, model update, expectations queued
  task automatic step(input bit w, input logic [DW-1:0] d, input bit t);
    bit wa, pp, sv;
    @(negedge clk);
    wr_en = w; wr_data = d; smp_tick = t;
    wa = w && (m_lvl != D);
    pp = t && m_play && (m_lvl != 0);
    sv = t && m_play && (m_lvl == 0);
    if (pp) begin rq_due.push_back(cyc + 1); rq_val.push_back(m_fifo.pop_front()); end
    if (sv) begin rq_due.push_back(cyc + 1); rq_val.push_back('0); end
    if (t && m_play) begin
      if (m_cnt == 0 && (m_lvl > HI || m_lvl < LO)) begin
        if (m_lvl > HI) begin if (m_tot < 7) m_tot++; end
        else begin if (m_tot > -8) m_tot--; end
        tq_due.push_back(cyc + 1); tq_up.push_back(m_lvl > HI); tq_tot.push_back(m_tot);
        m_cnt = HT - 1;
      end else if (m_cnt > 0) m_cnt--;
    end
    if (wa) m_fifo.push_back(d);
    if (m_lvl >= D / 2) m_play = 1'b1;
    m_lvl = m_lvl + int'(wa) - int'(pp);
    @(posedge clk);
    #1 wr_en = 1'b0; smp_tick = 1'b0;
  endtask

  // Monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rd_valid) begin
        if (rq_due.size() == 0) chk("R2 unexpected rd_valid", 1, 0);
        else begin
          chk("R4 read due cycle", cyc, rq_due.pop_front());
          chk("R4 or R5 read data", rd_data, rq_val.pop_front());
        end
      end
      if (trim_pulse) begin
        pulses++;
        if (tq_due.size() == 0) chk("R9 or R10 unexpected trim_pulse", 1, 0);
        else begin
          chk("R10 trim due cycle", cyc, tq_due.pop_front());
          chk("R7 or R8 trim_up", trim_up, tq_up.pop_front());
          chk("R11 trim_total", trim_total, tq_tot.pop_front());
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 fill_level", fill_level, 0);
    chk("R1 playing", playing, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 flags", {underrun, overrun}, 0);
    chk("R1 trim", {trim_pulse, trim_total}, 0);

    // R2: ticks before priming do nothing
    step(0, 0, 1);
    @(negedge clk);
    chk("R2 level after idle tick", fill_level, 0);
    chk("R2 underrun after idle tick", underrun, 0);
    for (int i = 0; i < 7; i++) step(1, DW'(16'h100 + i), 1);
    @(negedge clk);
    chk("R2 level below half", fill_level, 7);
    chk("R3 not yet playing", playing, 0);

    // R3: reach the midpoint
    step(1, 16'h107, 0);
    @(negedge clk);
    chk("R3 level at half", fill_level, 8);
    chk("R3 playing lags level", playing, 0);
    step(0, 0, 0);
    @(negedge clk);
    chk("R3 playing", playing, 1);

    // R4, R8, R10, R5: drain past empty
    pulses = 0;
    for (int i = 0; i < 12; i++) step(0, 0, 1);
    step(0, 0, 0);
    @(negedge clk);
    chk("R10 trims in drain window", pulses, 2);
    chk("R8 total after drain", trim_total, -2);
    chk("R5 underrun sticky", underrun, 1);
    chk("R4 level empty", fill_level, 0);

    // R6: overfill
    for (int i = 0; i < 20; i++) step(1, DW'(16'h200 + i), 0);
    @(negedge clk);
    chk("R6 level held at depth", fill_level, D);
    chk("R6 overrun sticky", overrun, 1);
    chk("R5 underrun still set", underrun, 1);

    // R7, R11: keep the level high to drive the total to its ceiling
    for (int i = 0; i < 90; i++) step(1, DW'(16'h300 + i), 1);
    step(0, 0, 0);
    @(negedge clk);
    chk("R11 total saturated high", trim_total, 7);

    // R9: settle into the band, then steady playout
    while (m_lvl > 8) step(0, 0, 1);
    for (int i = 0; i < HT; i++) step(1, DW'(16'h400 + i), 1);
    pulses = 0;
    for (int i = 0; i < 24; i++) step(1, DW'(16'h500 + i), 1);
    step(0, 0, 0);
    @(negedge clk);
    chk("R9 no trim inside band", pulses, 0);
    chk("R9 level inside band", fill_level, 8);

    // Flush and confirm nothing expected was left outstanding
    while (m_lvl > 0) step(0, 0, 1);
    repeat (3) step(0, 0, 0);
    @(negedge clk);
    chk("R4 reads outstanding", rq_due.size(), 0);
    chk("R10 trims outstanding", tq_due.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule